// File: doc/BRIEF.md
# User Interrupt Flag Control Unit

This block owns the one-bit user-interrupt enable flag of a processor core and carries out the three decoded operations that touch it: clear, set and test. The core's decoder presents one operation per strobe, together with the current mode conditions. These are a control enable bit, a 64-bit-mode indicator, an enclave-active indicator and a transactional-region indicator. From these the block decides in the same cycle whether the operation completes, faults as an invalid opcode, or aborts the enclosing transaction.

A completed clear or set changes the flag at the next clock edge. A look-ahead output, `deliver_ok`, already reflects the new value during the strobe cycle. The interrupt delivery logic can therefore honour the change at the very next instruction boundary. A completed test latches the flag into the carry status bit, forces the other five arithmetic status bits to zero and returns the carry as a result byte.

Top module: `uif_ctrl`

## Requirements
- R1: After synchronous reset the flag is 0, all six status bits are 0, the result byte is 0 and `test_valid` is 0.
- R2: A completed clear (op_code 2'b01) makes `flag` 0 after the next clock edge, and a completed set (op_code 2'b10) makes it 1.
- R3: During the strobe cycle, `deliver_ok` is 0 for a completed clear and 1 for a completed set; in every other cycle it equals `flag`.
- R4: An operation with op_code 2'b01, 2'b10 or 2'b11 is illegal when `cr_en` is 0, `long_mode` is 0 or `enclave` is 1. It raises `ud_fault` in the strobe cycle and changes neither the flag nor the status outputs.
- R5: A legal clear or set issued while `in_txn` is 1 raises `txn_abort` in the strobe cycle and leaves the flag unchanged.
- R6: A legal test (op_code 2'b11) issued while `in_txn` is 1 completes normally and raises no abort.
- R7: One cycle after a completed test, `cf` equals the flag value at the strobe, `zf`, `af`, `of_f`, `pf` and `sf` are 0, and `result` equals {7'b0, cf}. `test_valid` is 1 for exactly that one cycle.
- R8: When an operation is both illegal and inside a transaction, only `ud_fault` is raised and `txn_abort` stays 0.
- R9: With `op_valid` low, or with op_code 2'b00, neither pulse is raised and neither the flag nor the status outputs change.
- R10: The status bits and result byte keep their values until the next completed test; clears, sets, faults and aborts do not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 00 none, 01 clear, 10 set, 11 test |
| cr_en | input | 1 | Control-register enable for the feature |
| long_mode | input | 1 | Processor is in 64-bit mode |
| enclave | input | 1 | An enclave is executing |
| in_txn | input | 1 | Operation lies in a transactional region |
| flag | output | 1 | Current user-interrupt flag |
| deliver_ok | output | 1 | Delivery allowed at the next instruction boundary |
| cf | output | 1 | Carry status from the last test |
| zf | output | 1 | Zero status, cleared by test |
| af | output | 1 | Adjust status, cleared by test |
| of_f | output | 1 | Overflow status, cleared by test |
| pf | output | 1 | Parity status, cleared by test |
| sf | output | 1 | Sign status, cleared by test |
| result | output | 8 | Test result byte |
| test_valid | output | 1 | One-cycle pulse after a completed test |
| ud_fault | output | 1 | Invalid-opcode fault pulse |
| txn_abort | output | 1 | Transaction abort pulse |

## Verification
The hardest situation to reach is a collision of conditions: a clear or set that is inside a transaction and illegal at the same time, where priority alone decides the outcome. A close second is a test run inside a transaction, which must neither abort nor be confused with a clear or set. Directed cases build each of these combinations explicitly. Random stimulus then biases the mode inputs toward legality while still drawing each bad condition often, so faults, aborts and completions interleave with both flag values. Idle gaps between operations show that `test_valid` falls and that the status bits hold.

// File: rtl/uif_pkg.sv
package uif_pkg;
  localparam int OP_W  = 2;
  localparam int RES_W = 8;

  typedef enum logic [OP_W-1:0] {
    UOP_NONE = 2'b00,
    UOP_CLR  = 2'b01,
    UOP_SET  = 2'b10,
    UOP_TEST = 2'b11
  } uop_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic af;
    logic of_f;
    logic pf;
    logic sf;
  } uif_stat_t;
endpackage

// File: rtl/uif_gate.sv
module uif_gate
  import uif_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_code,
  input  logic            cr_en,
  input  logic            long_mode,
  input  logic            enclave,
  input  logic            in_txn,
  output logic            ud_fault,
  output logic            txn_abort,
  output logic            do_clr,
  output logic            do_set,
  output logic            do_test
);
  uop_e op;
  logic is_real, mode_ok, writes_flag;

  always_comb begin
    op          = uop_e'(op_code);
    is_real     = op_valid && (op != UOP_NONE);
    mode_ok     = cr_en && long_mode && !enclave;
    writes_flag = (op == UOP_CLR) || (op == UOP_SET);
    // mode check first, transaction check only for legal ops
    ud_fault    = is_real && !mode_ok;
    txn_abort   = is_real && mode_ok && in_txn && writes_flag;
    do_clr      = is_real && mode_ok && !in_txn && (op == UOP_CLR);
    do_set      = is_real && mode_ok && !in_txn && (op == UOP_SET);
    do_test     = is_real && mode_ok && (op == UOP_TEST);
  end

  // R8: fault and abort never together
  p_one_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    !(ud_fault && txn_abort));
  // R9: quiet without a strobe
  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> (!ud_fault && !txn_abort && !do_clr && !do_set && !do_test));
  // R6: a test never aborts
  p_test_noabort_r6: assert property (@(posedge clk) disable iff (rst)
    do_test |-> !txn_abort);
endmodule

// File: rtl/uif_flag_reg.sv
module uif_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic do_clr,
  input  logic do_set,
  output logic flag_q,
  output logic deliver_ok
);
  always_ff @(posedge clk) begin
    if (rst)         flag_q <= 1'b0;
    else if (do_set) flag_q <= 1'b1;
    else if (do_clr) flag_q <= 1'b0;
  end

  always_comb begin
    if (do_set)      deliver_ok = 1'b1;
    else if (do_clr) deliver_ok = 1'b0;
    else             deliver_ok = flag_q;
  end

  // R2
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    do_clr |=> !flag_q);
  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    do_set |=> flag_q);
  // R3: look-ahead matches the value the next cycle holds
  p_lookahead_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> flag_q == $past(deliver_ok));
endmodule

// File: rtl/uif_status.sv
module uif_status
  import uif_pkg::*;
#(
  parameter int RW = RES_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_test,
  input  logic          flag_q,
  output uif_stat_t     stat_q,
  output logic [RW-1:0] result_q,
  output logic          valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= '0;
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= do_test;
      if (do_test) begin
        stat_q    <= '0;
        stat_q.cf <= flag_q;
        result_q  <= RW'(flag_q);
      end
    end
  end

  // R7
  p_test_cf_r7: assert property (@(posedge clk) disable iff (rst)
    do_test |=> (valid_q && stat_q.cf == $past(flag_q) && !stat_q.zf
                 && !stat_q.sf && result_q == RW'(stat_q.cf)));
  // R10
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !do_test |=> ($stable(stat_q) && $stable(result_q) && !valid_q));
endmodule

// File: rtl/uif_ctrl.sv
module uif_ctrl
  import uif_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_code,
  input  logic            cr_en,
  input  logic            long_mode,
  input  logic            enclave,
  input  logic            in_txn,
  output logic            flag,
  output logic            deliver_ok,
  output logic            cf,
  output logic            zf,
  output logic            af,
  output logic            of_f,
  output logic            pf,
  output logic            sf,
  output logic [RES_W-1:0] result,
  output logic            test_valid,
  output logic            ud_fault,
  output logic            txn_abort
);
  logic do_clr, do_set, do_test;
  uif_stat_t stat;

  uif_gate u_gate (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .cr_en(cr_en), .long_mode(long_mode), .enclave(enclave), .in_txn(in_txn),
    .ud_fault(ud_fault), .txn_abort(txn_abort),
    .do_clr(do_clr), .do_set(do_set), .do_test(do_test)
  );

  uif_flag_reg u_flag (
    .clk(clk), .rst(rst), .do_clr(do_clr), .do_set(do_set),
    .flag_q(flag), .deliver_ok(deliver_ok)
  );

  uif_status #(.RW(RES_W)) u_stat (
    .clk(clk), .rst(rst), .do_test(do_test), .flag_q(flag),
    .stat_q(stat), .result_q(result), .valid_q(test_valid)
  );

  assign cf   = stat.cf;
  assign zf   = stat.zf;
  assign af   = stat.af;
  assign of_f = stat.of_f;
  assign pf   = stat.pf;
  assign sf   = stat.sf;

  // R4: illegal operation leaves the flag alone
  p_ud_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ud_fault |=> $stable(flag));
  // R5: aborted write leaves the flag alone
  p_abort_hold_r5: assert property (@(posedge clk) disable iff (rst)
    txn_abort |=> $stable(flag));
endmodule

// File: tb/tb_uif_ctrl.sv
module tb_uif_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [1:0] op_code = 2'b00;
  logic cr_en = 1'b1, long_mode = 1'b1, enclave = 1'b0, in_txn = 1'b0;
  logic flag, deliver_ok, cf, zf, af, of_f, pf, sf, test_valid, ud_fault, txn_abort;
  logic [7:0] result;

  int n_chk = 0;
  int n_err = 0;
  logic m_flag = 1'b0;
  logic m_cf = 1'b0;
  logic m_tv = 1'b0;

  always #4 clk = ~clk;

  uif_ctrl dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .cr_en(cr_en), .long_mode(long_mode), .enclave(enclave), .in_txn(in_txn),
    .flag(flag), .deliver_ok(deliver_ok), .cf(cf), .zf(zf), .af(af),
    .of_f(of_f), .pf(pf), .sf(sf), .result(result), .test_valid(test_valid),
    .ud_fault(ud_fault), .txn_abort(txn_abort)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic legal_f(input logic c, input logic l, input logic e);
    return c && l && !e;
  endfunction

  task automatic check_regs();
    chk("R2 flag", flag, m_flag);
    chk("R10/R7 cf", cf, m_cf);
    chk("R7 zf", zf, 0);
    chk("R7 af", af, 0);
    chk("R7 of", of_f, 0);
    chk("R7 pf", pf, 0);
    chk("R7 sf", sf, 0);
    chk("R7 result", result, {7'b0, m_cf});
    chk("R7 test_valid", test_valid, m_tv);
  endtask

  task automatic do_op(input logic v, input logic [1:0] op, input logic c,
                       input logic l, input logic e, input logic t);
    logic real_op, lg, exp_ud, exp_ab, wr, clr, st, tst, exp_dl;
    @(negedge clk);
    m_tv = 1'b0;
    check_regs();
    op_valid = v; op_code = op; cr_en = c; long_mode = l; enclave = e; in_txn = t;
    real_op = v && (op != 2'b00);
    lg      = legal_f(c, l, e);
    wr      = (op == 2'b01) || (op == 2'b10);
    exp_ud  = real_op && !lg;
    exp_ab  = real_op && lg && t && wr;
    clr     = real_op && lg && !t && (op == 2'b01);
    st      = real_op && lg && !t && (op == 2'b10);
    tst     = real_op && lg && (op == 2'b11);
    exp_dl  = st ? 1'b1 : (clr ? 1'b0 : m_flag);
    #1;
    chk("R4/R8 ud_fault", ud_fault, exp_ud);
    chk("R5/R8/R6/R9 txn_abort", txn_abort, exp_ab);
    chk("R3 deliver_ok", deliver_ok, exp_dl);
    if (tst) m_cf = m_flag;
    if (st) m_flag = 1'b1;
    if (clr) m_flag = 1'b0;
    m_tv = tst;
    @(negedge clk);
    check_regs();
    op_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 flag", flag, 0);
    chk("R1 cf", cf, 0);
    chk("R1 result", result, 0);
    chk("R1 test_valid", test_valid, 0);
    // R7 test with flag 0
    do_op(1, 2'b11, 1, 1, 0, 0);
    // R2 set, R3 look-ahead
    do_op(1, 2'b10, 1, 1, 0, 0);
    // R7 test with flag 1, R10 status then held
    do_op(1, 2'b11, 1, 1, 0, 0);
    // R6 test inside transaction
    do_op(1, 2'b11, 1, 1, 0, 1);
    // R5 clear inside transaction aborts
    do_op(1, 2'b01, 1, 1, 0, 1);
    // R4 each illegal condition, clear attempt
    do_op(1, 2'b01, 0, 1, 0, 0);
    do_op(1, 2'b01, 1, 0, 0, 0);
    do_op(1, 2'b01, 1, 1, 1, 0);
    // R4 illegal test keeps status
    do_op(1, 2'b11, 0, 1, 0, 0);
    // R8 illegal and in transaction
    do_op(1, 2'b01, 1, 1, 1, 1);
    do_op(1, 2'b10, 0, 0, 1, 1);
    // R9 no strobe, and opcode none
    do_op(0, 2'b01, 1, 1, 0, 0);
    do_op(1, 2'b00, 1, 1, 0, 0);
    // R2 clear, R10 status unchanged
    do_op(1, 2'b01, 1, 1, 0, 0);
    do_op(1, 2'b10, 1, 1, 0, 1);
    for (int i = 0; i < 400; i++) begin
      do_op(($urandom % 8) != 0, 2'($urandom), ($urandom % 6) != 0,
            ($urandom % 6) != 0, ($urandom % 6) == 0, ($urandom % 3) == 0);
    end
    // one synchronous reset mid-run, R1
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_flag = 1'b0; m_cf = 1'b0; m_tv = 1'b0;
    check_regs();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule